// File: doc/BRIEF.md
# Four-Channel Block-Move DMA Engine

This block moves 32-bit words between locations in memory on behalf of four independent channels. Each channel keeps a source address, a destination address, a block count and a small control word. An external agent starts a move by presenting a request that names a channel, a direction bit and one address. In a block move the direction bit decides which channel register the request address replaces. The other side comes from the channel. The length is the channel's block count in 32-byte units. When the move ends, the channel's source and destination registers hold their start values plus the length. The count is cleared, the channel's end flag is set, and a per-channel interrupt pulse is sent if that channel allows it.

A request flagged as port-mode does not use the channel registers. It moves an explicit byte size between memory and a streaming data port on the block's edge, in the direction the request gives. All memory traffic goes through one request/acknowledge port, one word per acknowledge. The engine serves one request at a time and shows this on a busy output. A configuration write port loads the channel registers and a global operation word. Writes to a control word or to the operation word are checked for a channel mode this engine cannot run, and any such write is reported.

Top module: `dma_engine`

## Requirements
- R1: After reset every channel register and the operation word read back as zero, and busy, irq and mem_req are low.
- R2: A block move copies exactly count*8 words (count*32 bytes) in ascending address order, with one read handshake and one write handshake per word.
- R3: With req_rw=1 (write), the request address is the destination and the channel source register is the source.
- R4: With req_rw=0 (read), the request address is the source and the channel destination register is the destination.
- R5: After a block move, the channel source and destination registers each equal their start value plus the length, and the count register reads zero.
- R6: After a block move the end flag (control bit 1) is set. irq[ch] pulses for one cycle only when the channel's interrupt-enable (control bit 2) is 1, and at most one irq bit is high at a time.
- R7: A port-mode request with req_rw=1 writes req_size/4 words taken from dp_wdata to memory, starting at req_addr and rising by 4 per word, with one dp_pop per word. No channel register changes.
- R8: A port-mode request with req_rw=0 reads req_size/4 words from memory starting at req_addr and delivers each on dp_rdata with a dp_push.
- R9: busy is high from the cycle after a request is accepted until the cycle after done. req_valid is ignored while busy.
- R10: mode_err pulses in the cycle after a configuration write in two cases. The first is a control write (sel 3) with enable bit 0 set while the operation word has master-enable (bit 0) set and external-request (bit 1) clear. The second is an operation-word write (sel 4) that has master-enable set and external-request clear while any channel has its enable bit set.
- R11: A block move with count 0 makes no memory access, yet still writes back the addresses, clears the count and sets the end flag.
- R12: mem_req stays high and mem_addr stays stable until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel selected for write and readback |
| cfg_sel | input | 3 | Register: 0 source, 1 destination, 2 count, 3 control, 4 operation word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Readback of the selected register |
| req_valid | input | 1 | Transfer request |
| req_ch | input | 2 | Channel of the request |
| req_rw | input | 1 | 1: request address is the write side; 0: read side |
| req_single | input | 1 | 1: port-mode transfer using the data port |
| req_addr | input | 32 | Request address |
| req_size | input | 16 | Byte size for port mode (multiple of 4) |
| busy | output | 1 | Request in service |
| done | output | 1 | One-cycle completion marker |
| irq | output | 4 | Per-channel end interrupt pulse |
| mode_err | output | 1 | Unsupported-mode report pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when 1 |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| dp_wdata | input | 32 | Data port word toward memory |
| dp_pop | output | 1 | dp_wdata consumed |
| dp_rdata | output | 32 | Data port word from memory |
| dp_push | output | 1 | dp_rdata valid |

## Verification
A wrong running address or word counter shows up on mem_addr at the very next handshake. It also shows up at completion, because the written-back registers are the running addresses. A bad count therefore leaves a readable source or destination value off by a multiple of 4. A missed read/write step appears as a handshake count other than twice the word count, or as wrong data in the destination words. A wrong end-of-move decision shows as a missing or extra irq pulse one cycle after the final acknowledge. A stale mode or busy flag is seen one cycle after the offending write or request.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        SEL_SRC  = 3'd0,
        SEL_DST  = 3'd1,
        SEL_CNT  = 3'd2,
        SEL_CTRL = 3'd3,
        SEL_OPR  = 3'd4
    } reg_sel_e;

    localparam int CTRL_DE  = 0;
    localparam int CTRL_TE  = 1;
    localparam int CTRL_IE  = 2;
    localparam int OPR_ME   = 0;
    localparam int OPR_EXT  = 1;

    typedef struct packed {
        logic ie;
        logic te;
        logic de;
    } ctrl_t;

    typedef enum logic [1:0] {
        XS_IDLE,
        XS_READ,
        XS_WRITE,
        XS_FIN
    } xs_e;

    function automatic logic mode_bad(input logic me, input logic ext, input logic de);
        return me & ~ext & de;
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CW  = 24,
    parameter int CHW = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [CHW-1:0]           wr_ch,
    input  logic [2:0]               wr_sel,
    input  logic [DW-1:0]            wr_data,
    input  logic                     wb_en,
    input  logic [CHW-1:0]           wb_ch,
    input  logic [AW-1:0]            wb_src,
    input  logic [AW-1:0]            wb_dst,
    input  logic [CHW-1:0]           rd_ch,
    input  logic [2:0]               rd_sel,
    output logic [DW-1:0]            rd_data,
    output logic [NCH-1:0][AW-1:0]   src_q,
    output logic [NCH-1:0][AW-1:0]   dst_q,
    output logic [NCH-1:0][CW-1:0]   cnt_q,
    output logic [NCH-1:0]           de_vec,
    output logic [NCH-1:0]           ie_vec,
    output logic                     opr_me,
    output logic                     opr_ext
);

    ctrl_t [NCH-1:0] ctrl_q;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                src_q[g]  <= '0;
                dst_q[g]  <= '0;
                cnt_q[g]  <= '0;
                ctrl_q[g] <= '0;
            end else if (wb_en && wb_ch == CHW'(g)) begin
                src_q[g]     <= wb_src;
                dst_q[g]     <= wb_dst;
                cnt_q[g]     <= '0;
                ctrl_q[g].te <= 1'b1;
            end else if (wr_en && wr_ch == CHW'(g)) begin
                case (reg_sel_e'(wr_sel))
                    SEL_SRC:  src_q[g] <= AW'(wr_data);
                    SEL_DST:  dst_q[g] <= AW'(wr_data);
                    SEL_CNT:  cnt_q[g] <= CW'(wr_data);
                    SEL_CTRL: begin
                        ctrl_q[g].de <= wr_data[CTRL_DE];
                        ctrl_q[g].te <= wr_data[CTRL_TE];
                        ctrl_q[g].ie <= wr_data[CTRL_IE];
                    end
                    default: ;
                endcase
            end
        end
        assign de_vec[g] = ctrl_q[g].de;
        assign ie_vec[g] = ctrl_q[g].ie;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            opr_me  <= 1'b0;
            opr_ext <= 1'b0;
        end else if (wr_en && wr_sel == SEL_OPR) begin
            opr_me  <= wr_data[OPR_ME];
            opr_ext <= wr_data[OPR_EXT];
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_sel))
            SEL_SRC:  rd_data = DW'(src_q[rd_ch]);
            SEL_DST:  rd_data = DW'(dst_q[rd_ch]);
            SEL_CNT:  rd_data = DW'(cnt_q[rd_ch]);
            SEL_CTRL: begin
                rd_data[CTRL_DE] = ctrl_q[rd_ch].de;
                rd_data[CTRL_TE] = ctrl_q[rd_ch].te;
                rd_data[CTRL_IE] = ctrl_q[rd_ch].ie;
            end
            SEL_OPR: begin
                rd_data[OPR_ME]  = opr_me;
                rd_data[OPR_EXT] = opr_ext;
            end
            default: rd_data = '0;
        endcase
    end

    AST_WB_SETS_TE: assert property (@(posedge clk) disable iff (rst)
        wb_en |=> ctrl_q[$past(wb_ch)].te); // R6
    AST_WB_CLEARS_CNT: assert property (@(posedge clk) disable iff (rst)
        wb_en |=> cnt_q[$past(wb_ch)] == '0); // R5

endmodule

// File: rtl/dma_mode_chk.sv
module dma_mode_chk
    import dma_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [2:0]     wr_sel,
    input  logic [2:0]     wr_bits,
    input  logic [NCH-1:0] de_vec,
    input  logic           opr_me,
    input  logic           opr_ext,
    output logic           mode_err
);

    logic bad;

    always_comb begin
        bad = 1'b0;
        if (wr_en) begin
            if (wr_sel == SEL_CTRL)
                bad = mode_bad(opr_me, opr_ext, wr_bits[CTRL_DE]);
            else if (wr_sel == SEL_OPR)
                bad = mode_bad(wr_bits[OPR_ME], wr_bits[OPR_EXT], |de_vec);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode_err <= 1'b0;
        else     mode_err <= bad;
    end

    AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        mode_err |-> $past(wr_en)); // R10

endmodule

// File: rtl/dma_xfer.sv
module dma_xfer
    import dma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CW  = 24,
    parameter int SZW = 16,
    parameter int CHW = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    input  logic [CHW-1:0] req_ch,
    input  logic           req_rw,
    input  logic           req_single,
    input  logic [AW-1:0]  req_addr,
    input  logic [SZW-1:0] req_size,
    input  logic [AW-1:0]  ch_src,
    input  logic [AW-1:0]  ch_dst,
    input  logic [CW-1:0]  ch_cnt,
    input  logic [NCH-1:0] ie_vec,
    output logic           busy,
    output logic           done,
    output logic [NCH-1:0] irq,
    output logic           wb_en,
    output logic [CHW-1:0] wb_ch,
    output logic [AW-1:0]  wb_src,
    output logic [AW-1:0]  wb_dst,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ack,
    input  logic [DW-1:0]  dp_wdata,
    output logic           dp_pop,
    output logic [DW-1:0]  dp_rdata,
    output logic           dp_push
);

    localparam int LW = (CW + 3 > SZW) ? CW + 3 : SZW;

    xs_e            st;
    logic [CHW-1:0] ch_q;
    logic           single_q;
    logic [AW-1:0]  src_q;
    logic [AW-1:0]  dst_q;
    logic [LW-1:0]  left_q;
    logic [DW-1:0]  buf_q;

    logic [AW-1:0]  start_src;
    logic [AW-1:0]  start_dst;
    logic [LW-1:0]  start_left;

    always_comb begin
        if (req_single) begin
            start_src  = req_addr;
            start_dst  = req_addr;
            start_left = LW'(req_size >> 2);
        end else begin
            start_src  = req_rw ? ch_src : req_addr;
            start_dst  = req_rw ? req_addr : ch_dst;
            start_left = LW'({ch_cnt, 3'b000});
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= XS_IDLE;
            ch_q     <= '0;
            single_q <= 1'b0;
            src_q    <= '0;
            dst_q    <= '0;
            left_q   <= '0;
            buf_q    <= '0;
        end else begin
            case (st)
                XS_IDLE: begin
                    if (req_valid) begin
                        ch_q     <= req_ch;
                        single_q <= req_single;
                        src_q    <= start_src;
                        dst_q    <= start_dst;
                        left_q   <= start_left;
                        if (start_left == '0)
                            st <= XS_FIN;
                        else if (req_single && req_rw)
                            st <= XS_WRITE;
                        else
                            st <= XS_READ;
                    end
                end
                XS_READ: begin
                    if (mem_ack) begin
                        buf_q <= mem_rdata;
                        src_q <= src_q + AW'(4);
                        if (single_q) begin
                            left_q <= left_q - LW'(1);
                            if (left_q == LW'(1)) st <= XS_FIN;
                        end else begin
                            st <= XS_WRITE;
                        end
                    end
                end
                XS_WRITE: begin
                    if (mem_ack) begin
                        dst_q  <= dst_q + AW'(4);
                        left_q <= left_q - LW'(1);
                        if (left_q == LW'(1))
                            st <= XS_FIN;
                        else if (!single_q)
                            st <= XS_READ;
                    end
                end
                XS_FIN:  st <= XS_IDLE;
                default: st <= XS_IDLE;
            endcase
        end
    end

    assign busy      = (st != XS_IDLE);
    assign done      = (st == XS_FIN);
    assign mem_req   = (st == XS_READ) || (st == XS_WRITE);
    assign mem_we    = (st == XS_WRITE);
    assign mem_addr  = (st == XS_WRITE) ? dst_q : src_q;
    assign mem_wdata = single_q ? dp_wdata : buf_q;
    assign dp_pop    = (st == XS_WRITE) && single_q && mem_ack;
    assign dp_push   = (st == XS_READ) && single_q && mem_ack;
    assign dp_rdata  = mem_rdata;
    assign wb_en     = done && !single_q;
    assign wb_ch     = ch_q;
    assign wb_src    = src_q;
    assign wb_dst    = dst_q;

    always_comb begin
        irq = '0;
        if (done && !single_q && ie_vec[ch_q]) irq[ch_q] = 1'b1;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R12
    AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq)); // R6
    AST_DONE_FREES: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R9
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
        busy && !done && req_valid |=> $stable(ch_q) && $stable(single_q)); // R9
    AST_PUSH_ON_READ: assert property (@(posedge clk) disable iff (rst)
        dp_push |-> !mem_we); // R8

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CW  = 24,
    parameter int SZW = 16,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [2:0]     cfg_sel,
    input  logic [DW-1:0]  cfg_wdata,
    output logic [DW-1:0]  cfg_rdata,
    input  logic           req_valid,
    input  logic [CHW-1:0] req_ch,
    input  logic           req_rw,
    input  logic           req_single,
    input  logic [AW-1:0]  req_addr,
    input  logic [SZW-1:0] req_size,
    output logic           busy,
    output logic           done,
    output logic [NCH-1:0] irq,
    output logic           mode_err,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ack,
    input  logic [DW-1:0]  dp_wdata,
    output logic           dp_pop,
    output logic [DW-1:0]  dp_rdata,
    output logic           dp_push
);

    logic [NCH-1:0][AW-1:0] src_q;
    logic [NCH-1:0][AW-1:0] dst_q;
    logic [NCH-1:0][CW-1:0] cnt_q;
    logic [NCH-1:0]         de_vec;
    logic [NCH-1:0]         ie_vec;
    logic                   opr_me;
    logic                   opr_ext;
    logic                   wb_en;
    logic [CHW-1:0]         wb_ch;
    logic [AW-1:0]          wb_src;
    logic [AW-1:0]          wb_dst;

    dma_chan_regs #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW), .CHW(CHW)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(cfg_we), .wr_ch(cfg_ch), .wr_sel(cfg_sel), .wr_data(cfg_wdata),
        .wb_en(wb_en), .wb_ch(wb_ch), .wb_src(wb_src), .wb_dst(wb_dst),
        .rd_ch(cfg_ch), .rd_sel(cfg_sel), .rd_data(cfg_rdata),
        .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q),
        .de_vec(de_vec), .ie_vec(ie_vec),
        .opr_me(opr_me), .opr_ext(opr_ext)
    );

    dma_mode_chk #(.NCH(NCH)) u_chk (
        .clk(clk), .rst(rst),
        .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_bits(cfg_wdata[2:0]),
        .de_vec(de_vec), .opr_me(opr_me), .opr_ext(opr_ext),
        .mode_err(mode_err)
    );

    dma_xfer #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW), .SZW(SZW), .CHW(CHW)) u_xfer (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ch(req_ch), .req_rw(req_rw),
        .req_single(req_single), .req_addr(req_addr), .req_size(req_size),
        .ch_src(src_q[req_ch]), .ch_dst(dst_q[req_ch]), .ch_cnt(cnt_q[req_ch]),
        .ie_vec(ie_vec),
        .busy(busy), .done(done), .irq(irq),
        .wb_en(wb_en), .wb_ch(wb_ch), .wb_src(wb_src), .wb_dst(wb_dst),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .dp_wdata(dp_wdata), .dp_pop(dp_pop), .dp_rdata(dp_rdata), .dp_push(dp_push)
    );

    AST_IRQ_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        (|irq) |-> done && busy); // R6

endmodule

// File: tb/tb_dma_engine.sv
`timescale 1ns/1ps
module tb_dma_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [1:0]  req_ch = '0;
    logic        req_rw = 1'b0;
    logic        req_single = 1'b0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_size = '0;
    logic        busy, done, mode_err;
    logic [3:0]  irq;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [31:0] dp_wdata;
    logic        dp_pop, dp_push;
    logic [31:0] dp_rdata;

    int checks_n = 0;
    int fail_n   = 0;

    always #2 clk = ~clk;

    dma_engine dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ch(req_ch), .req_rw(req_rw),
        .req_single(req_single), .req_addr(req_addr), .req_size(req_size),
        .busy(busy), .done(done), .irq(irq), .mode_err(mode_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .dp_wdata(dp_wdata), .dp_pop(dp_pop), .dp_rdata(dp_rdata), .dp_push(dp_push)
    );

    // memory model: 256 words, decision at negedge, consumed at posedge
    logic [31:0] mem [0:255];
    logic        stall = 1'b0;
    logic        stall_ph = 1'b0;
    int          acc_n = 0;

    function automatic logic [31:0] pat(input int idx);
        return 32'hA000_0000 + idx;
    endfunction

    always @(negedge clk) begin
        if (mem_req && !(stall && stall_ph)) begin
            mem_ack = 1'b1;
            if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
            else        mem_rdata = mem[mem_addr[9:2]];
            acc_n = acc_n + 1;
        end else begin
            mem_ack = 1'b0;
        end
        stall_ph = ~stall_ph;
    end

    // data port model
    int          dp_idx = 0;
    int          cap_n = 0;
    logic [31:0] cap [0:15];
    assign dp_wdata = 32'h5EED_0000 + dp_idx;

    always @(posedge clk) begin
        if (dp_pop)  dp_idx <= dp_idx + 1;
        if (dp_push) begin
            cap[cap_n % 16] <= dp_rdata;
            cap_n <= cap_n + 1;
        end
    end

    // interrupt monitor
    int         irq_hits = 0;
    logic [3:0] irq_last = '0;
    always @(posedge clk) begin
        if (|irq) begin
            irq_hits <= irq_hits + 1;
            irq_last <= irq;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks_n++;
        if (act !== exp) begin
            fail_n++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] ch, input logic [2:0] sel, input logic [31:0] d,
                      output logic err);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        err = mode_err;
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] ch, input logic [2:0] sel, output logic [31:0] v);
        @(negedge clk);
        cfg_ch = ch; cfg_sel = sel;
        #1;
        v = cfg_rdata;
    endtask

    task automatic start(input logic [1:0] ch, input logic rw, input logic single,
                         input logic [31:0] addr, input logic [15:0] size);
        @(negedge clk);
        req_valid = 1'b1; req_ch = ch; req_rw = rw; req_single = single;
        req_addr = addr; req_size = size;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (done !== 1'b1 && n < 4000) begin
            @(negedge clk);
            n++;
        end
        if (done !== 1'b1) begin
            checks_n++; fail_n++;
            $display("FAIL %s completion actual=timeout expected=done", tag);
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 4; s++) begin
                rd(c[1:0], s[2:0], v);
                chk("R1 channel register reset", v, 32'h0);
            end
        end
        rd(2'd0, 3'd4, v);
        chk("R1 operation word reset", v, 32'h0);
        chk("R1 busy low", {31'b0, busy}, 32'h0);
        chk("R1 mem_req low", {31'b0, mem_req}, 32'h0);
        chk("R1 irq low", {28'b0, irq}, 32'h0);
    endtask

    task automatic t_dual_write();
        logic [31:0] v;
        logic e;
        int h0;
        wr(2'd1, 3'd0, 32'h100, e);
        wr(2'd1, 3'd2, 32'd1, e);
        wr(2'd1, 3'd3, 32'h4, e);
        h0 = irq_hits;
        acc_n = 0;
        start(2'd1, 1'b1, 1'b0, 32'h200, 16'd0);
        wait_done("R3 dual write");
        for (int k = 0; k < 8; k++)
            chk("R3 destination word from channel source", mem[(32'h200 >> 2) + k], pat((32'h100 >> 2) + k));
        chk("R2 handshakes for count 1", acc_n, 32'd16);
        rd(2'd1, 3'd0, v); chk("R5 source writeback", v, 32'h120);
        rd(2'd1, 3'd1, v); chk("R5 destination writeback", v, 32'h220);
        rd(2'd1, 3'd2, v); chk("R5 count cleared", v, 32'h0);
        rd(2'd1, 3'd3, v); chk("R6 end flag set with enable", v, 32'h6);
        chk("R6 one irq pulse", irq_hits - h0, 32'd1);
        chk("R6 irq on channel 1", {28'b0, irq_last}, 32'h2);
    endtask

    task automatic t_dual_read();
        logic [31:0] v;
        logic e;
        int h0;
        wr(2'd2, 3'd1, 32'h300, e);
        wr(2'd2, 3'd2, 32'd2, e);
        h0 = irq_hits;
        acc_n = 0;
        stall = 1'b1;
        start(2'd2, 1'b0, 1'b0, 32'h040, 16'd0);
        wait_done("R4 dual read");
        stall = 1'b0;
        for (int k = 0; k < 16; k++)
            chk("R4 destination word from request source", mem[(32'h300 >> 2) + k], pat((32'h040 >> 2) + k));
        chk("R2 handshakes for count 2", acc_n, 32'd32);
        rd(2'd2, 3'd0, v); chk("R5 source writeback read", v, 32'h080);
        rd(2'd2, 3'd1, v); chk("R5 destination writeback read", v, 32'h340);
        rd(2'd2, 3'd3, v); chk("R6 end flag set without enable", v, 32'h2);
        chk("R6 no irq when disabled", irq_hits - h0, 32'd0);
    endtask

    task automatic t_single_write();
        logic [31:0] v;
        logic e;
        int i0, h0;
        wr(2'd0, 3'd0, 32'h55, e);
        i0 = dp_idx;
        h0 = irq_hits;
        start(2'd0, 1'b1, 1'b1, 32'h380, 16'd12);
        wait_done("R7 port write");
        for (int k = 0; k < 3; k++)
            chk("R7 port word in memory", mem[(32'h380 >> 2) + k], 32'h5EED_0000 + i0 + k);
        chk("R7 pops", dp_idx - i0, 32'd3);
        chk("R7 word after block untouched", mem[(32'h380 >> 2) + 3], pat((32'h380 >> 2) + 3));
        rd(2'd0, 3'd0, v); chk("R7 channel source unchanged", v, 32'h55);
        rd(2'd0, 3'd3, v); chk("R7 channel control unchanged", v, 32'h0);
        chk("R7 no irq", irq_hits - h0, 32'd0);
    endtask

    task automatic t_single_read();
        int n0;
        n0 = cap_n;
        stall = 1'b1;
        start(2'd0, 1'b0, 1'b1, 32'h100, 16'd8);
        wait_done("R8 port read");
        stall = 1'b0;
        chk("R8 pushes", cap_n - n0, 32'd2);
        chk("R8 first word", cap[n0 % 16], pat(32'h100 >> 2));
        chk("R8 second word", cap[(n0 + 1) % 16], pat((32'h100 >> 2) + 1));
    endtask

    task automatic t_busy();
        logic e;
        logic [31:0] v;
        int i0;
        wr(2'd3, 3'd0, 32'h000, e);
        wr(2'd3, 3'd2, 32'd1, e);
        i0 = dp_idx;
        stall = 1'b1;
        start(2'd3, 1'b1, 1'b0, 32'h3A0, 16'd0);
        chk("R9 busy after accept", {31'b0, busy}, 32'h1);
        start(2'd0, 1'b1, 1'b1, 32'h3C0, 16'd4);
        chk("R9 still busy", {31'b0, busy}, 32'h1);
        wait_done("R9 busy move");
        stall = 1'b0;
        chk("R9 busy cleared", {31'b0, busy}, 32'h0);
        chk("R9 ignored request wrote nothing", mem[32'h3C0 >> 2], pat(32'h3C0 >> 2));
        chk("R9 ignored request popped nothing", dp_idx - i0, 32'd0);
        chk("R2 busy move data", mem[(32'h3A0 >> 2) + 7], pat(7));
        rd(2'd3, 3'd1, v); chk("R5 busy move dst", v, 32'h3C0);
    endtask

    task automatic t_zero();
        logic e;
        logic [31:0] v;
        wr(2'd0, 3'd0, 32'h10, e);
        wr(2'd0, 3'd2, 32'd0, e);
        acc_n = 0;
        start(2'd0, 1'b1, 1'b0, 32'h20, 16'd0);
        wait_done("R11 zero count");
        chk("R11 no memory access", acc_n, 32'd0);
        rd(2'd0, 3'd0, v); chk("R11 source unchanged value", v, 32'h10);
        rd(2'd0, 3'd1, v); chk("R11 destination takes request", v, 32'h20);
        rd(2'd0, 3'd3, v); chk("R11 end flag", v, 32'h2);
    endtask

    task automatic t_mode();
        logic e;
        wr(2'd0, 3'd4, 32'h1, e);
        chk("R10 master only, no channel enabled", {31'b0, e}, 32'h0);
        wr(2'd0, 3'd3, 32'h1, e);
        chk("R10 control enable without external mode", {31'b0, e}, 32'h1);
        @(negedge clk);
        chk("R10 report is one cycle", {31'b0, mode_err}, 32'h0);
        wr(2'd0, 3'd4, 32'h3, e);
        chk("R10 external mode accepted", {31'b0, e}, 32'h0);
        wr(2'd1, 3'd3, 32'h1, e);
        chk("R10 control write under external mode", {31'b0, e}, 32'h0);
        wr(2'd0, 3'd4, 32'h1, e);
        chk("R10 operation write with enabled channel", {31'b0, e}, 32'h1);
        wr(2'd0, 3'd4, 32'h0, e);
        chk("R10 master off", {31'b0, e}, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = pat(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_dual_write();
        t_dual_read();
        t_single_write();
        t_single_read();
        t_busy();
        t_zero();
        t_mode();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks_n, fail_n);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks_n++;
        fail_n++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks_n, fail_n);
        $finish;
    end

endmodule